// File: doc/BRIEF.md
# Flags Register Unit with Privilege-Checked Updates

This block holds the 16-bit processor status word and a 6-bit extended status field (bits 21:16 of the wide status word). It carries out the small set of micro-operations that touch these flags directly:
- toggle, clear or set the carry flag;
- clear or set the direction flag;
- clear or set the interrupt-enable flag;
- load the low status byte from an accumulator byte, or copy it out to one;
- apply a 16-bit or 32-bit word taken from the stack, or build the 16-bit or 32-bit word to be pushed.

A pop does not load every bit. Which bits it may write depends on the current privilege level, the I/O privilege field held in the flags, protected-mode enable and a processor-generation select. Reserved bits are forced to fixed values.

An operation is presented with `op_valid` while `busy` is low. The unit then stays busy for the operation's fixed latency. When that latency ends it pulses `done` for one cycle, and the new flags appear in that same cycle. A privilege violation raises `fault` together with `done` and leaves all state as it was. Stack memory, instruction decode and delivery of the fault belong to the surrounding pipeline. The virtual-8086 indication is supplied by that pipeline as an input.

Top module: `flags_unit`

## Requirements
- R1: After reset `flags_out` = 0x0002, `ext_out` = 0, and `busy`, `done` and `fault` are low. At all times bit 1 of `flags_out` reads 1, and bits 3, 5 and 15 read 0.
- R2: Carry and direction operations each take 2 cycles. Carry is bit 0 and direction is bit 10. The opcodes are: `op_code` 0 toggles carry, 1 clears carry, 2 sets carry, 3 clears direction, 4 sets direction. No other bit changes.
- R3: Opcode 5 clears the interrupt flag (bit 9) in 3 cycles. Opcode 6 sets it in 2 cycles. When `prot_en`=1 and `cpl` is greater than the I/O privilege field (bits 13:12), both raise `fault` and change nothing.
- R4: Opcode 7 takes 3 cycles. It writes low-byte bits 7,6,4,2,0 from `operand[7:0]`, keeps bits 15:8, forces bit 1 to 1 and clears bits 3 and 5. Opcode 8 takes 3 cycles and places `flags_out[7:0]` on `acc_out` without changing the flags.
- R5: Opcode 11 (16-bit pop, 5 cycles) behaves by mode. With `prot_en`=0 (except on generation 0) or with `cpl`=0, it loads bits 14:12, 11:6, 4, 2, 0 from `operand`. In protected mode with 0 < `cpl` <= I/O privilege field, it also keeps bits 13:12. With `cpl` above that field, it keeps bits 13:12 and 9.
- R6: With `cpu_gen`=0 (oldest generation) and `prot_en`=0, a pop keeps bits 14:12 and loads only bits 11:6, 4, 2, 0.
- R7: Opcode 12 (32-bit pop, 5 cycles) applies the 16-bit rule to the low half. Extended bits 16 and 17 keep their value. Bit 18 is loaded only when `cpu_gen` >= 2, and bit 21 only when `cpu_gen` = 3.
- R8: Opcode 9 (push, 4 cycles) puts `flags_out` on `push_data[15:0]` with the upper half zero. Opcode 10 (wide push, 4 cycles) adds extended bit 18 at position 18, and bit 21 at position 21 only when `cpu_gen` = 3. All other upper bits are 0.
- R9: Opcodes 9 to 12 raise `fault` and change nothing when `v86_mode`=1 and the I/O privilege field is below 3.
- R10: If `op_valid` is sampled with `busy` low at edge N, then `busy` is high after N and `done` is high for exactly the one cycle following edge N+L-1, where L is the latency. `op_valid` is ignored while `busy` is high, and the flags do not change while busy.
- R11: `fault` is high only together with `done`. A faulting operation leaves `flags_out`, `ext_out`, `push_data` and `acc_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, taken when busy is low |
| op_code | input | 4 | Operation select (see R2 to R9) |
| operand | input | 32 | Accumulator byte or popped word |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected mode enable |
| cpu_gen | input | 2 | 0 oldest, 1 base 32-bit, 2 adds bit 18, 3 adds bit 21 |
| v86_mode | input | 1 | Virtual-8086 mode indication |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Protection fault, valid with done |
| flags_out | output | 16 | Status word |
| ext_out | output | 6 | Extended status bits 21:16 |
| push_data | output | 32 | Word to push |
| acc_out | output | 8 | Stored low status byte |

## Verification
The bench builds the unit with its default maximum latency of 5, which covers every operation's latency. Flags, pushed words and faults are predicted with an arithmetic model that expresses pop permissions as a writable-bit set, not as the design's masks. It sweeps all four generations, both modes, all four privilege levels and all four I/O privilege values for the pop and interrupt operations. It also covers all 256 accumulator bytes for the low-byte load, the wide pop and push across generations, and the virtual-8086 fault for every I/O privilege value.

// File: rtl/flags_pkg.sv
package flags_pkg;
  typedef enum logic [3:0] {
    OP_TGLC = 4'd0, OP_CLRC = 4'd1, OP_SETC = 4'd2, OP_CLRD = 4'd3,
    OP_SETD = 4'd4, OP_CLRI = 4'd5, OP_SETI = 4'd6, OP_LDLO = 4'd7,
    OP_STLO = 4'd8, OP_PSH16 = 4'd9, OP_PSH32 = 4'd10, OP_POP16 = 4'd11,
    OP_POP32 = 4'd12
  } fop_e;

  localparam int BIT_C = 0;
  localparam int BIT_I = 9;
  localparam int BIT_D = 10;

  function automatic logic [2:0] op_latency(input logic [3:0] op);
    case (op)
      OP_CLRI, OP_LDLO, OP_STLO: return 3'd3;
      OP_PSH16, OP_PSH32:        return 3'd4;
      OP_POP16, OP_POP32:        return 3'd5;
      default:                   return 3'd2;
    endcase
  endfunction

  function automatic logic is_stack_op(input logic [3:0] op);
    return (op == OP_PSH16) || (op == OP_PSH32) || (op == OP_POP16) || (op == OP_POP32);
  endfunction

  // Low 16 bits after a pop, by mode
  function automatic logic [15:0] pop_low(input logic [15:0] cur, input logic [15:0] w,
                                          input logic [1:0] gen, input logic prot,
                                          input logic [1:0] cpl, input logic io_ok);
    logic [15:0] r;
    if (gen == 2'd0 && !prot)    r = (cur & 16'h7000) | (w & 16'h0FD5);
    else if (!prot || cpl == 0)  r = w & 16'h7FD5;
    else if (io_ok)              r = (cur & 16'h3000) | (w & 16'h4FD5);
    else                         r = (cur & 16'h3200) | (w & 16'h4DD5);
    return r | 16'h0002;
  endfunction

  function automatic logic [5:0] pop_ext(input logic [5:0] cur, input logic [31:0] w,
                                         input logic [1:0] gen);
    logic [5:0] r;
    r = {1'b0, 2'b00, 1'b0, cur[1:0]};
    r[2] = (gen >= 2'd2) ? w[18] : cur[2];
    r[5] = (gen == 2'd3) ? w[21] : cur[5];
    return r;
  endfunction

  function automatic logic [15:0] push_hi(input logic [5:0] ext, input logic [1:0] gen);
    logic [15:0] r;
    r = 16'h0000;
    r[2] = ext[2];
    r[5] = ext[5] & (gen == 2'd3);
    return r;
  endfunction
endpackage

// File: rtl/flags_guard.sv
module flags_guard
  import flags_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] cpl,
  input  logic       prot_en,
  input  logic [1:0] iopl,
  input  logic       v86_mode,
  output logic       io_ok,
  output logic       viol
);
  logic int_op;
  assign io_ok  = !prot_en || (cpl <= iopl);
  assign int_op = (op == OP_CLRI) || (op == OP_SETI);
  assign viol   = (int_op && !io_ok) || (is_stack_op(op) && v86_mode && (iopl != 2'd3));
endmodule

// File: rtl/flags_alu.sv
module flags_alu
  import flags_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int EXT_W  = 6
) (
  input  logic [3:0]        op,
  input  logic [31:0]       operand,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic [EXT_W-1:0]  cur_ext,
  input  logic [1:0]        gen,
  input  logic              prot_en,
  input  logic [1:0]        cpl,
  input  logic              io_ok,
  output logic [FLAG_W-1:0] nxt_flags,
  output logic [EXT_W-1:0]  nxt_ext,
  output logic [31:0]       push_word,
  output logic              push_wr,
  output logic              acc_wr
);
  always_comb begin
    nxt_flags = cur_flags;
    nxt_ext   = cur_ext;
    push_word = {16'h0000, cur_flags};
    push_wr   = 1'b0;
    acc_wr    = 1'b0;
    case (op)
      OP_TGLC:  nxt_flags[BIT_C] = ~cur_flags[BIT_C];
      OP_CLRC:  nxt_flags[BIT_C] = 1'b0;
      OP_SETC:  nxt_flags[BIT_C] = 1'b1;
      OP_CLRD:  nxt_flags[BIT_D] = 1'b0;
      OP_SETD:  nxt_flags[BIT_D] = 1'b1;
      OP_CLRI:  nxt_flags[BIT_I] = 1'b0;
      OP_SETI:  nxt_flags[BIT_I] = 1'b1;
      OP_LDLO:  nxt_flags = {cur_flags[15:8], (operand[7:0] & 8'hD5) | 8'h02};
      OP_STLO:  acc_wr = 1'b1;
      OP_PSH16: push_wr = 1'b1;
      OP_PSH32: begin
        push_wr   = 1'b1;
        push_word = {push_hi(cur_ext, gen), cur_flags};
      end
      OP_POP16: nxt_flags = pop_low(cur_flags, operand[15:0], gen, prot_en, cpl, io_ok);
      OP_POP32: begin
        nxt_flags = pop_low(cur_flags, operand[15:0], gen, prot_en, cpl, io_ok);
        nxt_ext   = pop_ext(cur_ext, operand, gen);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flags_seq.sv
module flags_seq #(
  parameter int MAX_LAT = 5,
  localparam int CNT_W = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] lat,
  output logic             busy,
  output logic             finish
);
  logic [CNT_W-1:0] cnt;
  assign finish = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= lat - CNT_W'(1);
    end else if (finish) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/flags_unit.sv
module flags_unit
  import flags_pkg::*;
#(
  parameter int MAX_LAT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic [31:0] operand,
  input  logic [1:0]  cpl,
  input  logic        prot_en,
  input  logic [1:0]  cpu_gen,
  input  logic        v86_mode,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [15:0] flags_out,
  output logic [5:0]  ext_out,
  output logic [31:0] push_data,
  output logic [7:0]  acc_out
);
  localparam int CNT_W = $clog2(MAX_LAT + 1);

  logic        accept, finish, io_ok, viol;
  logic [15:0] flags_q, nxt_flags, pend_flags;
  logic [5:0]  ext_q, nxt_ext, pend_ext;
  logic [31:0] push_word, pend_push;
  logic        push_wr, acc_wr, pend_push_wr, pend_acc_wr, pend_viol;

  assign accept = op_valid && !busy;

  flags_guard u_guard (
    .op(op_code), .cpl(cpl), .prot_en(prot_en), .iopl(flags_q[13:12]),
    .v86_mode(v86_mode), .io_ok(io_ok), .viol(viol)
  );

  flags_alu #(.FLAG_W(16), .EXT_W(6)) u_alu (
    .op(op_code), .operand(operand), .cur_flags(flags_q), .cur_ext(ext_q),
    .gen(cpu_gen), .prot_en(prot_en), .cpl(cpl), .io_ok(io_ok),
    .nxt_flags(nxt_flags), .nxt_ext(nxt_ext), .push_word(push_word),
    .push_wr(push_wr), .acc_wr(acc_wr)
  );

  flags_seq #(.MAX_LAT(MAX_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .lat(CNT_W'(op_latency(op_code))), .busy(busy), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q      <= 16'h0002;
      ext_q        <= '0;
      push_data    <= '0;
      acc_out      <= '0;
      done         <= 1'b0;
      fault        <= 1'b0;
      pend_flags   <= 16'h0002;
      pend_ext     <= '0;
      pend_push    <= '0;
      pend_push_wr <= 1'b0;
      pend_acc_wr  <= 1'b0;
      pend_viol    <= 1'b0;
    end else begin
      done  <= finish;
      fault <= finish && pend_viol;
      if (accept) begin
        pend_flags   <= nxt_flags;
        pend_ext     <= nxt_ext;
        pend_push    <= push_word;
        pend_push_wr <= push_wr;
        pend_acc_wr  <= acc_wr;
        pend_viol    <= viol;
      end
      if (finish && !pend_viol) begin
        flags_q <= pend_flags;
        ext_q   <= pend_ext;
        if (pend_push_wr) push_data <= pend_push;
        if (pend_acc_wr)  acc_out   <= flags_q[7:0];
      end
    end
  end

  assign flags_out = flags_q;
  assign ext_out   = ext_q;
endmodule

module flags_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [15:0] flags_out,
  input logic [5:0]  ext_out
);
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[1] && !flags_out[3] && !flags_out[5] && !flags_out[15]);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r10_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> $stable(flags_out));
  a_r11_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
  a_r11_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(rst_n)) |-> ($stable(flags_out) && $stable(ext_out)));
  a_r7_ext_kept_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ext_out[1:0] == 2'b00);
endmodule

bind flags_unit flags_unit_chk u_chk (.*);

// File: tb/flags_unit_test.sv
module flags_unit_test;
  logic        clk = 0, rst_n = 0, op_valid = 0, prot_en = 0, v86_mode = 0;
  logic [3:0]  op_code = 0;
  logic [31:0] operand = 0;
  logic [1:0]  cpl = 0, cpu_gen = 1;
  logic        busy, done, fault;
  logic [15:0] flags_out;
  logic [5:0]  ext_out;
  logic [31:0] push_data;
  logic [7:0]  acc_out;
  int n_chk = 0, n_bad = 0;
  logic [15:0] m_flags = 16'h0002;
  logic [5:0]  m_ext = 0;
  logic [31:0] m_push = 0;
  logic [7:0]  m_acc = 0;

  always #4 clk = ~clk;

  flags_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [3:0] op);
    if (op == 5 || op == 7 || op == 8) return 3;
    if (op == 9 || op == 10) return 4;
    if (op == 11 || op == 12) return 5;
    return 2;
  endfunction

  // Pop model written as a set of writable bits
  function automatic logic [15:0] model_pop(input logic [15:0] old, input logic [15:0] w,
      input logic [1:0] g, input logic p, input logic [1:0] c);
    logic [15:0] wr;
    logic [1:0] io = old[13:12];
    wr = 16'h0DD5;
    if (!(p && c != 0 && c > io)) wr[9] = 1;
    if (!(g == 0 && !p)) begin
      wr[14] = 1;
      if (!p || c == 0) begin wr[12] = 1; wr[13] = 1; end
    end
    return ((old & ~wr) | (w & wr)) | 16'h0002;
  endfunction

  task automatic run(input string req, input logic [3:0] op, input logic [31:0] w,
      input logic [1:0] c, input logic p, input logic [1:0] g, input logic v);
    logic [1:0] io = m_flags[13:12];
    logic xf;
    int k;
    logic [15:0] ef = m_flags;
    logic [5:0]  ee = m_ext;
    logic [31:0] ep = m_push;
    logic [7:0]  ea = m_acc;
    xf = ((op == 5 || op == 6) && p && c > io) || (op >= 9 && op <= 12 && v && io != 3);
    if (!xf) case (op)
      0: ef[0] = ~ef[0];
      1: ef[0] = 0;
      2: ef[0] = 1;
      3: ef[10] = 0;
      4: ef[10] = 1;
      5: ef[9] = 0;
      6: ef[9] = 1;
      7: ef[7:0] = {w[7], w[6], 1'b0, w[4], 1'b0, w[2], 1'b1, w[0]};
      8: ea = m_flags[7:0];
      9: ep = {16'h0, m_flags};
      10: ep = {10'h0, m_ext[5] & (g == 3), 2'b0, m_ext[2], 2'b0, m_flags};
      11: ef = model_pop(m_flags, w[15:0], g, p, c);
      12: begin
        ef = model_pop(m_flags, w[15:0], g, p, c);
        if (g >= 2) ee[2] = w[18];
        if (g == 3) ee[5] = w[21];
      end
      default: ;
    endcase
    @(negedge clk);
    op_valid = 1; op_code = op; operand = w; cpl = c; prot_en = p; cpu_gen = g; v86_mode = v;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0;
    k = 1;
    while (!done && k < 12) begin @(negedge clk); k++; end
    chk({req, " latency R10"}, k, exp_lat(op));
    chk({req, " fault"}, fault, xf);
    chk({req, " flags"}, flags_out, ef);
    chk({req, " ext"}, ext_out, ee);
    chk({req, " push R8"}, push_data, ep);
    chk({req, " acc R4"}, acc_out, ea);
    @(negedge clk);
    chk({req, " done pulse R10"}, done, 0);
    m_flags = ef; m_ext = ee; m_push = ep; m_acc = ea;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flags", flags_out, 16'h0002);
    chk("R1 reset ext", ext_out, 0);
    chk("R1 reset busy/done/fault", {busy, done, fault}, 0);
    rst_n = 1;
    // R2 carry and direction
    run("R2 stc", 2, 0, 0, 0, 1, 0);
    run("R2 cmc", 0, 0, 0, 0, 1, 0);
    run("R2 cmc", 0, 0, 0, 0, 1, 0);
    run("R2 clc", 1, 0, 0, 0, 1, 0);
    run("R2 std", 4, 0, 0, 0, 1, 0);
    run("R2 cld", 3, 0, 0, 0, 1, 0);
    // R4 low byte load over all bytes, then store
    for (int b = 0; b < 256; b++) begin
      run("R4 ldlo", 7, {24'hABCDEF, b[7:0]}, 0, 0, 1, 0);
      if (b % 37 == 0) run("R4 stlo", 8, 0, 0, 0, 1, 0);
    end
    // R3 R5 R6 sweep of generation, mode, privilege and I/O privilege
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 4; c++)
          for (int i = 0; i < 4; i++) begin
            run("R5 setup", 11, {16'h0, 2'b00, i[1:0], 12'h200}, 0, 0, 1, 0);
            run("R3 cli", 5, 0, c[1:0], p[0], g[1:0], 0);
            run("R3 sti", 6, 0, c[1:0], p[0], g[1:0], 0);
            run("R5 R6 pop16", 11, {16'h0, 16'hFFFF ^ (16'h1111 << c)}, c[1:0], p[0], g[1:0], 0);
            run("R5 pop16 zero", 11, 0, c[1:0], p[0], g[1:0], 0);
            run("R8 push16", 9, 0, c[1:0], p[0], g[1:0], 0);
          end
    // R7 R8 wide pop and push across generations
    for (int g = 0; g < 4; g++) begin
      run("R7 pop32 ones", 12, 32'hFFFFFFFF, 0, 0, g[1:0], 0);
      run("R8 push32", 10, 0, 0, 0, g[1:0], 0);
      run("R7 pop32 zero", 12, 32'h0, 0, 0, g[1:0], 0);
      run("R8 push32", 10, 0, 0, 0, g[1:0], 0);
    end
    run("R7 pop32 id", 12, 32'h00240ED5, 0, 0, 3, 0);
    run("R8 push32 no id", 10, 0, 0, 0, 2, 0);
    // R9 virtual-8086 faults
    for (int i = 0; i < 4; i++) begin
      run("R9 setup", 11, {16'h0, 2'b00, i[1:0], 12'h0C1}, 0, 0, 1, 0);
      run("R9 R11 push16", 9, 0, 3, 1, 2, 1);
      run("R9 R11 push32", 10, 0, 3, 1, 2, 1);
      run("R9 R11 pop16", 11, 32'h0000_0ED5, 3, 1, 2, 1);
      run("R9 R11 pop32", 12, 32'h0024_0000, 3, 1, 3, 1);
    end
    // R10 request while busy is ignored
    run("R10 clc", 1, 0, 0, 0, 1, 0);
    @(negedge clk);
    op_valid = 1; op_code = 11; operand = 32'h0000_00C5; cpl = 0; prot_en = 0; cpu_gen = 1;
    @(posedge clk);
    @(negedge clk);
    op_code = 2;
    @(negedge clk);
    chk("R10 busy held", busy, 1);
    op_valid = 0;
    repeat (8) @(negedge clk);
    chk("R10 ignored while busy", flags_out, 16'h00C7);
    chk("R10 idle after", {busy, done}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule